// File: doc/BRIEF.md
# Guarded Address Relocation Unit

This block turns program-relative addresses into absolute memory addresses for a processor that runs several programs at once. It keeps two relocation windows, one for instruction fetches and one for operand traffic. Each window has an 18-bit base and a pair of 9-bit block numbers. A block is 512 words, so the block number of an address is its bits 17:9. On every request the block adds the matching base to the 18-bit address. The sum wraps modulo 2^18.

When the guard bit is set, the block also checks the absolute block number against the window's inclusive lower and upper block bounds. An access that falls outside the window does not reach memory. Instead it produces a one-cycle fault pulse that carries the access kind. When the guard bit is clear, addresses are relocated and never faulted.

All window fields and the guard bit are written together in one cycle from a state-register load port. Results appear one clock after the request.

Top module: `addr_reloc_guard`

## Requirements
- R1: After synchronous reset, both bases are 0, both lower bounds are 0, both upper bounds are 511, the guard bit is clear, and `mem_req` and `prot_fault` are low.
- R2: With `psr_load` high, every window field and the guard bit take the port values at that clock edge. A request presented in the same cycle is handled with the values held before the load.
- R3: The access kind is encoded on `req_kind` as 0 = fetch, 1 = read, 2 = write and 3 = alternate operand. Kind 0 uses the instruction window. Kinds 1, 2 and 3 use the data window.
- R4: The absolute address is `(req_addr + base) mod 2^18`, using the base of the selected window.
- R5: With guard set, an access faults exactly when its absolute block number (bits 17:9) is below the lower bound or above the upper bound. Both bounds themselves pass.
- R6: With guard clear, no access faults, whatever the bounds are.
- R7: A faulting access leaves `mem_req` low. It raises `prot_fault` for that one cycle, with `out_kind` equal to the request's kind.
- R8: A request's `mem_req`/`mem_addr` or `prot_fault`/`out_kind` are valid exactly one clock after `req_valid` is sampled high. A cycle without a request gives `mem_req` and `prot_fault` low one clock later.
- R9: With guard set and the lower bound above the upper bound, every access through that window faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psr_load | input | 1 | Load all window fields and the guard bit |
| psr_guard | input | 1 | Guard bit value to load |
| psr_ibase | input | 18 | Instruction window base to load |
| psr_ilo | input | 9 | Instruction window lower block bound |
| psr_ihi | input | 9 | Instruction window upper block bound |
| psr_dbase | input | 18 | Data window base to load |
| psr_dlo | input | 9 | Data window lower block bound |
| psr_dhi | input | 9 | Data window upper block bound |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | Access kind (0 fetch, 1 read, 2 write, 3 alternate operand) |
| req_addr | input | 18 | Program-relative address |
| mem_req | output | 1 | Relocated access passed to memory |
| mem_addr | output | 18 | Absolute address |
| prot_fault | output | 1 | One-cycle protection fault pulse |
| out_kind | output | 2 | Access kind of the reported access or fault |

## Verification
Each result is due on the clock edge after its request: the address or fault, the access kind, and the quiet outputs after an idle cycle. A state load changes the outcome only from the request after the load. The bench drives inputs on the falling edge and keeps a behavioural model of the windows. That model computes what the next rising edge must produce, and the bench compares it on the following falling edge, every cycle. The model applies a load only after it has computed the expectation for the request that shares the load's cycle. This follows the ordering set in R2.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    localparam int ADDR_W    = 18;
    localparam int BLK_LOG2  = 9;
    localparam int BLK_W     = ADDR_W - BLK_LOG2;
    localparam int NUM_PAIRS = 2;
    localparam int PIDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

    localparam int PAIR_INSTR = 0;
    localparam int PAIR_DATA  = 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [PIDX_W-1:0] pidx_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef struct packed {
        addr_t base;
        blk_t  lo;
        blk_t  hi;
    } window_t;

    typedef struct packed {
        logic                     guard;
        window_t [NUM_PAIRS-1:0]  win;
    } psr_t;

    // Fetches go through the instruction window, everything else through data.
    function automatic pidx_t pair_of(acc_e kind);
        return (kind == ACC_FETCH) ? pidx_t'(PAIR_INSTR) : pidx_t'(PAIR_DATA);
    endfunction

    function automatic blk_t block_of(addr_t a);
        return a[ADDR_W-1:BLK_LOG2];
    endfunction

    function automatic logic outside(blk_t b, window_t w);
        return (b < w.lo) || (b > w.hi);
    endfunction

    function automatic psr_t reset_psr();
        psr_t p;
        p.guard = 1'b0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            p.win[i].base = '0;
            p.win[i].lo   = '0;
            p.win[i].hi   = '1;
        end
        return p;
    endfunction

endpackage

// File: rtl/reloc_state_regs.sv
module reloc_state_regs
    import reloc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  psr_t d,
    output psr_t q
);

    localparam psr_t RESET_VAL = reset_psr();

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/reloc_pair_select.sv
module reloc_pair_select
    import reloc_pkg::*;
(
    input  psr_t       st,
    input  logic [1:0] kind,
    output window_t    win,
    output logic       guard
);

    pidx_t idx;

    always_comb begin
        idx   = pair_of(acc_e'(kind));
        win   = st.win[idx];
        guard = st.guard;
    end

endmodule

// File: rtl/reloc_window_check.sv
module reloc_window_check
    import reloc_pkg::*;
(
    input  window_t win,
    input  logic    guard,
    input  addr_t   rel,
    output addr_t   abs_addr,
    output logic    viol
);

    blk_t blk;

    always_comb begin
        abs_addr = rel + win.base;
        blk      = block_of(abs_addr);
        viol     = guard && outside(blk, win);
    end

endmodule

// File: rtl/addr_reloc_guard.sv
module addr_reloc_guard
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psr_load,
    input  logic              psr_guard,
    input  logic [ADDR_W-1:0] psr_ibase,
    input  logic [BLK_W-1:0]  psr_ilo,
    input  logic [BLK_W-1:0]  psr_ihi,
    input  logic [ADDR_W-1:0] psr_dbase,
    input  logic [BLK_W-1:0]  psr_dlo,
    input  logic [BLK_W-1:0]  psr_dhi,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              prot_fault,
    output logic [1:0]        out_kind
);

    psr_t    load_val;
    psr_t    state_q;
    window_t sel_win;
    logic    sel_guard;
    addr_t   abs_addr;
    logic    viol;

    always_comb begin
        load_val.guard                = psr_guard;
        load_val.win[PAIR_INSTR].base = psr_ibase;
        load_val.win[PAIR_INSTR].lo   = psr_ilo;
        load_val.win[PAIR_INSTR].hi   = psr_ihi;
        load_val.win[PAIR_DATA].base  = psr_dbase;
        load_val.win[PAIR_DATA].lo    = psr_dlo;
        load_val.win[PAIR_DATA].hi    = psr_dhi;
    end

    reloc_state_regs u_state (
        .clk  (clk),
        .rst  (rst),
        .load (psr_load),
        .d    (load_val),
        .q    (state_q)
    );

    reloc_pair_select u_sel (
        .st    (state_q),
        .kind  (req_kind),
        .win   (sel_win),
        .guard (sel_guard)
    );

    reloc_window_check u_chk_win (
        .win      (sel_win),
        .guard    (sel_guard),
        .rel      (req_addr),
        .abs_addr (abs_addr),
        .viol     (viol)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req    <= 1'b0;
            prot_fault <= 1'b0;
            mem_addr   <= '0;
            out_kind   <= '0;
        end else begin
            mem_req    <= req_valid && !viol;
            prot_fault <= req_valid && viol;
            if (req_valid) begin
                mem_addr <= abs_addr;
                out_kind <= req_kind;
            end
        end
    end

endmodule

// File: rtl/reloc_guard_checker.sv
module reloc_guard_checker
    import reloc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              prot_fault,
    input logic [1:0]        out_kind,
    input logic              guard_q,
    input logic [ADDR_W-1:0] sel_base
);

    // R7: a faulting access never also reaches memory
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && prot_fault));

    // R8: no request, no output one clock later
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_req && !prot_fault));

    // R8: every request produces exactly one outcome one clock later
    a_r8_served: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (mem_req || prot_fault));

    // R6: guard clear never faults
    a_r6_no_fault_unguarded: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !guard_q) |=> !prot_fault);

    // R4: absolute address is the wrapped sum of address and selected base
    a_r4_relocated_sum: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!mem_req || (mem_addr == addr_t'($past(req_addr) + $past(sel_base)))));

    // R7: reported kind follows the request
    a_r7_kind_reported: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_kind == $past(req_kind)));

endmodule

bind addr_reloc_guard reloc_guard_checker u_guard_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_addr   (req_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .prot_fault (prot_fault),
    .out_kind   (out_kind),
    .guard_q    (state_q.guard),
    .sel_base   (sel_win.base)
);

// File: tb/addr_reloc_guard_test.sv
module addr_reloc_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psr_load = 1'b0;
    logic        psr_guard = 1'b0;
    logic [17:0] psr_ibase = '0;
    logic [8:0]  psr_ilo = '0;
    logic [8:0]  psr_ihi = '0;
    logic [17:0] psr_dbase = '0;
    logic [8:0]  psr_dlo = '0;
    logic [8:0]  psr_dhi = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [17:0] req_addr = '0;
    logic        mem_req;
    logic [17:0] mem_addr;
    logic        prot_fault;
    logic [1:0]  out_kind;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state: index 0 instruction window, 1 data window
    bit          m_guard;
    logic [17:0] m_base [2];
    logic [8:0]  m_lo   [2];
    logic [8:0]  m_hi   [2];

    always #4 clk = ~clk;   // 125 MHz

    addr_reloc_guard uut (
        .clk(clk), .rst(rst),
        .psr_load(psr_load), .psr_guard(psr_guard),
        .psr_ibase(psr_ibase), .psr_ilo(psr_ilo), .psr_ihi(psr_ihi),
        .psr_dbase(psr_dbase), .psr_dlo(psr_dlo), .psr_dhi(psr_dhi),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .prot_fault(prot_fault), .out_kind(out_kind)
    );

    task automatic model_reset();
        m_guard = 0;
        for (int i = 0; i < 2; i++) begin
            m_base[i] = '0; m_lo[i] = '0; m_hi[i] = 9'h1FF;
        end
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, predict, then check at the next falling edge.
    task automatic step(input bit v, input logic [1:0] k, input logic [17:0] a, input string tag);
        int          w;
        logic [17:0] abs_a;
        logic [8:0]  blk;
        bit          bad;
        bit          e_mem, e_flt;
        req_valid = v; req_kind = k; req_addr = a;
        w     = (k == 2'd0) ? 0 : 1;
        abs_a = 18'((int'(a) + int'(m_base[w])) % 262144);
        blk   = abs_a[17:9];
        bad   = m_guard && ((blk < m_lo[w]) || (blk > m_hi[w]));
        e_mem = v && !bad;
        e_flt = v && bad;
        if (psr_load) begin
            m_guard = psr_guard;
            m_base[0] = psr_ibase; m_lo[0] = psr_ilo; m_hi[0] = psr_ihi;
            m_base[1] = psr_dbase; m_lo[1] = psr_dlo; m_hi[1] = psr_dhi;
        end
        @(negedge clk);
        cmp(tag, "mem_req", int'(mem_req), int'(e_mem));
        cmp(tag, "prot_fault", int'(prot_fault), int'(e_flt));
        if (e_mem) cmp(tag, "mem_addr", int'(mem_addr), int'(abs_a));
        if (v) cmp(tag, "out_kind", int'(out_kind), int'(k));
    endtask

    task automatic set_psr(input bit g, input logic [17:0] ib, input logic [8:0] il, input logic [8:0] ih,
                           input logic [17:0] db, input logic [8:0] dl, input logic [8:0] dh);
        psr_guard = g;
        psr_ibase = ib; psr_ilo = il; psr_ihi = ih;
        psr_dbase = db; psr_dlo = dl; psr_dhi = dh;
        psr_load  = 1'b1;
    endtask

    task automatic load_idle(input bit g, input logic [17:0] ib, input logic [8:0] il, input logic [8:0] ih,
                             input logic [17:0] db, input logic [8:0] dl, input logic [8:0] dh);
        set_psr(g, ib, il, ih, db, dl, dh);
        step(0, 2'd0, '0, "R2");
        psr_load = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet after reset, identity relocation with default window
        step(0, 2'd0, 18'h0, "R1");
        step(1, 2'd0, 18'h12345, "R1");
        step(1, 2'd2, 18'h3FFFF, "R1");

        // R2: request in the load cycle uses the old (reset) values
        set_psr(0, 18'h01000, 9'd2, 9'd3, 18'h20000, 9'd0, 9'd0);
        step(1, 2'd0, 18'h00100, "R2");
        psr_load = 1'b0;
        // R3: fetch uses instruction base, other kinds use data base
        step(1, 2'd0, 18'h00100, "R3");
        step(1, 2'd1, 18'h00100, "R3");
        step(1, 2'd2, 18'h00200, "R3");
        step(1, 2'd3, 18'h00300, "R3");
        // R6: bounds exclude these addresses, but guard clear never faults
        step(1, 2'd0, 18'h3F000, "R6");
        step(1, 2'd1, 18'h1FFFF, "R6");
        step(0, 2'd0, 18'h0, "R8");

        // R4: wrap modulo 2^18
        load_idle(0, 18'h3FFFF, 9'd0, 9'd511, 18'h3FF00, 9'd0, 9'd511);
        step(1, 2'd1, 18'h00200, "R4");
        step(1, 2'd0, 18'h00001, "R4");
        for (int i = 0; i < 40; i++) begin
            if (i % 10 == 0)
                load_idle(0, 18'($urandom), 9'($urandom), 9'($urandom),
                          18'($urandom), 9'($urandom), 9'($urandom));
            step(($urandom % 4) != 0, 2'($urandom), 18'($urandom), "R4");
        end

        // R5: inclusive block bounds under guard
        load_idle(1, 18'h00400, 9'd2, 9'd5, 18'h20000, 9'h100, 9'h1FF);
        step(1, 2'd0, 18'h00000, "R5");     // block 2 = lower bound
        step(1, 2'd0, 18'h007FF, "R5");     // block 5 last word = upper bound
        step(1, 2'd0, 18'h00800, "R5");     // block 6, fault
        step(1, 2'd0, 18'h3FFFF, "R5");     // wraps to block 1, fault
        step(1, 2'd1, 18'h00000, "R5");     // data block 0x100 = lower bound
        step(1, 2'd2, 18'h1FFFF, "R5");     // data block 0x1FF = upper bound
        // R7: faults with kind reported, then quiet
        step(1, 2'd2, 18'h20000, "R7");     // wraps to 0, fault, write
        step(1, 2'd3, 18'h3FE00, "R7");     // fault, alternate
        step(1, 2'd0, 18'h01000, "R7");     // fault, fetch
        step(0, 2'd0, 18'h0, "R7");
        step(1, 2'd1, 18'h00400, "R7");

        // R9: inverted window faults everything
        load_idle(1, 18'h0, 9'd5, 9'd4, 18'h0, 9'd300, 9'd10);
        step(1, 2'd0, 18'h00A00, "R9");
        step(1, 2'd0, 18'h00800, "R9");
        step(1, 2'd1, 18'h25800, "R9");
        step(1, 2'd2, 18'h01400, "R9");

        // R5: random windows under guard
        for (int i = 0; i < 80; i++) begin
            if (i % 8 == 0)
                load_idle(1, 18'($urandom), 9'($urandom), 9'($urandom),
                          18'($urandom), 9'($urandom), 9'($urandom));
            step(($urandom % 5) != 0, 2'($urandom), 18'($urandom), "R5");
        end

        // R1: reset restores defaults
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        step(1, 2'd1, 18'h2ABCD, "R1");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule